// File: doc/BRIEF.md
# Packet Mailbox Controller

This block connects a processor register bus to a byte-wide packet link. Software holds one frame in each direction inside the block. To send, it writes a frame length and then pushes that many bytes through a data register. The block streams the frame out only after the last byte has arrived. To receive, the block takes one frame from the link into a buffer. It loads a count register with the frame length, and software drains the bytes one register read at a time while the count falls to zero.

Three interrupt sources share one request line: transmit finished, receive data waiting, and a test source under software control. Receive is tied to software acknowledgement. No further frame enters until software has cleared the receive flag and drained the buffer. The register window is sixteen 32-bit words, chosen by a word index equal to the byte offset divided by four.

Top module: `pkt_mailbox`

## Requirements
- R1: Word 0 reads 0x5350494D and word 1 reads 0x3054454E. Together they form a 64-bit identity word whose least significant byte is 0x4D.
- R2: Word 2 (busy) has these bits:
  - bit 0 is 1 while a transmit frame is being streamed out;
  - bit 1 is 1 while a receive frame has been partly taken;
  - the word reads 0 when the block is idle.
- R3: When the link delivers the final byte of a frame, word 3 (receive count) holds the frame's byte count. Each read of word 7 returns the next received byte, in arrival order, in bits 7:0 with bits 31:8 zero, and lowers the count by one.
- R4: A read of word 7 while the receive count is 0 returns 0 and leaves the count at 0.
- R5: Transmit filling works as follows:
  - writing word 4 sets the transmit length;
  - each write to word 8 stores bits 7:0 of the write data as the next byte;
  - tx_valid stays low until the length-th byte is stored, and at that point word 4 reads 0;
  - writes to words 4 and 8 are ignored while a frame is streaming.
- R6: Transmit bytes leave in the order they were written. tx_last is high on the final byte only, and tx_valid, tx_data and tx_last hold while tx_ready is low.
- R7: Word 5 bit 0 is set when the final transmit byte is accepted, and bit 1 is set when the final receive byte is taken. Writing 1 to a bit clears it. The irq output equals bit 0 OR bit 1 OR bit 31 of word 5.
- R8: rx_ready is high only while word 5 bit 1 is clear and the receive count is 0. No byte of a new frame is taken otherwise.
- R9: Word 5 bit 31 is the test interrupt:
  - writing a value with bit 31 set raises it;
  - writing the value 0 to word 5 clears it;
  - a read of word 5 returns it and clears it after that read.
- R10: Writes to words 0, 1, 2, 3 and 6 change nothing. Word 6 reads the constant INFO_VAL, and words 9 to 15 read 0.
- R11: DEPTH bytes are buffered per direction, and DEPTH may be at most 65536. A transmit length above DEPTH is stored as DEPTH. Received bytes past DEPTH are dropped, and the count then reads DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 4 | Word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word, combinational |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Link receive byte valid |
| rx_data | input | 8 | Link receive byte |
| rx_last | input | 1 | Final byte of receive frame |
| rx_ready | output | 1 | Block takes a receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of transmit frame |
| tx_ready | input | 1 | Link accepts transmit byte |

## Verification
Transmit frames of 1 byte, 5 bytes and DEPTH bytes are driven under three link behaviours:
- tx_ready held low, which separates "stream starts only after the last byte" from early starts and exposes the busy flag;
- tx_ready toggling every cycle, which tests that data holds under back-pressure;
- tx_ready always high, which tests the ordering of back-to-back handshakes.

Receive frames are tried at these lengths:
- 4 bytes, the plain case;
- 2 bytes, with a pause between them that exposes the receive busy bit;
- 20 bytes, beyond DEPTH, which separates dropping the excess bytes from wrapping over the buffer.

A further frame is offered while the receive flag is still set, which shows whether acknowledgement really gates intake. A model of the three interrupt bits is compared with irq on every clock. This catches a set or clear that lands one cycle off.

// File: rtl/pkt_mailbox.sv
module pkt_mailbox #(
  parameter int DEPTH = 1024,
  parameter logic [31:0] INFO_VAL = 32'h0000_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = 17;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [63:0] IDENT = 64'h3054_454E_5350_494D;
  localparam logic [3:0] W_IDLO = 4'd0, W_IDHI = 4'd1, W_BUSY = 4'd2, W_RXCNT = 4'd3,
                         W_TXCNT = 4'd4, W_ICTL = 4'd5, W_INFO = 4'd6, W_RXBUF = 4'd7,
                         W_TXBUF = 4'd8;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [CW-1:0] tx_len, tx_fill, rx_wr, rx_cnt;
  logic [AW-1:0] tx_pos, tx_end, rx_rd;
  logic          tx_act, rx_act, int_txd, int_rxd, int_test;

  wire rd     = bus_sel && !bus_wr;
  wire wr     = bus_sel && bus_wr;
  wire ic_wr  = wr && bus_word == W_ICTL;
  wire ic_rd  = rd && bus_word == W_ICTL;
  wire len_wr = wr && bus_word == W_TXCNT && !tx_act;
  wire tx_put = wr && bus_word == W_TXBUF && !tx_act && tx_len != '0;
  wire tx_fire = tx_valid && tx_ready;
  wire rx_take = rx_valid && rx_ready;
  wire rx_room = rx_wr < DEPTH_C;
  wire rx_pop = rd && bus_word == W_RXBUF && rx_cnt != '0;
  wire [CW-1:0] len_c = (bus_wdata > 32'(DEPTH)) ? DEPTH_C : bus_wdata[CW-1:0];

  assign tx_valid = tx_act;
  assign tx_data  = tx_mem[tx_pos];
  assign tx_last  = tx_act && tx_pos == tx_end;
  assign rx_ready = !int_rxd && rx_cnt == '0;
  assign irq      = int_txd | int_rxd | int_test;

  always_ff @(posedge clk) begin
    if (tx_put) tx_mem[tx_fill[AW-1:0]] <= bus_wdata[7:0];
    if (rx_take && rx_room) rx_mem[rx_wr[AW-1:0]] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_len <= '0;
      tx_fill <= '0;
      tx_pos <= '0;
      tx_end <= '0;
      tx_act <= 1'b0;
    end else begin
      if (len_wr) begin
        tx_len <= len_c;
        tx_fill <= '0;
      end else if (tx_put) begin
        if (tx_fill + 1'b1 == tx_len) begin
          tx_act <= 1'b1;
          tx_pos <= '0;
          tx_end <= tx_fill[AW-1:0];
          tx_len <= '0;
          tx_fill <= '0;
        end else begin
          tx_fill <= tx_fill + 1'b1;
        end
      end
      if (tx_fire) begin
        if (tx_last) tx_act <= 1'b0;
        else tx_pos <= tx_pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wr <= '0;
      rx_cnt <= '0;
      rx_rd <= '0;
      rx_act <= 1'b0;
    end else if (rx_take) begin
      if (rx_room) rx_wr <= rx_wr + 1'b1;
      if (rx_last) begin
        rx_cnt <= rx_room ? rx_wr + 1'b1 : rx_wr;
        rx_wr <= '0;
        rx_rd <= '0;
        rx_act <= 1'b0;
      end else begin
        rx_act <= 1'b1;
      end
    end else if (rx_pop) begin
      rx_cnt <= rx_cnt - 1'b1;
      rx_rd <= rx_rd + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_txd <= 1'b0;
      int_rxd <= 1'b0;
      int_test <= 1'b0;
    end else begin
      if (tx_fire && tx_last) int_txd <= 1'b1;
      else if (ic_wr && bus_wdata[0]) int_txd <= 1'b0;
      if (rx_take && rx_last) int_rxd <= 1'b1;
      else if (ic_wr && bus_wdata[1]) int_rxd <= 1'b0;
      if (ic_wr) begin
        if (bus_wdata[31]) int_test <= 1'b1;
        else if (bus_wdata == 32'd0) int_test <= 1'b0;
      end else if (ic_rd) begin
        int_test <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_word)
      W_IDLO:  bus_rdata = IDENT[31:0];
      W_IDHI:  bus_rdata = IDENT[63:32];
      W_BUSY:  bus_rdata = {30'd0, rx_act, tx_act};
      W_RXCNT: bus_rdata = {{(32-CW){1'b0}}, rx_cnt};
      W_TXCNT: bus_rdata = {{(32-CW){1'b0}}, tx_len};
      W_ICTL:  bus_rdata = {int_test, 29'd0, int_rxd, int_txd};
      W_INFO:  bus_rdata = INFO_VAL;
      W_RXBUF: bus_rdata = (rx_cnt != '0) ? {24'd0, rx_mem[rx_rd]} : 32'd0;
      default: bus_rdata = 32'd0;
    endcase
  end

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R5
  tx_len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_len == '0);
  // R7
  tx_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> bus_rdata[0] || bus_word != W_ICTL || int_txd);
  // R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(int_rxd) && int_rxd |-> rx_cnt <= $past(rx_cnt));
  // R4
  rx_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_word == W_RXBUF && rx_cnt == '0 && !(rx_valid && rx_ready && rx_last)
    |=> rx_cnt == '0);
  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= DEPTH_C && tx_len <= DEPTH_C);
endmodule

// File: tb/tb_pkt_mailbox.sv
`timescale 1ns/1ps
module tb_pkt_mailbox;
  localparam int DEPTH = 16;
  localparam logic [3:0] W_IDLO = 0, W_IDHI = 1, W_BUSY = 2, W_RXCNT = 3, W_TXCNT = 4,
                         W_ICTL = 5, W_INFO = 6, W_RXBUF = 7, W_TXBUF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_word = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, rx_valid = 0, rx_last = 0, rx_ready, tx_valid, tx_last, tx_ready = 0;
  logic [7:0] rx_data = 0, tx_data;

  int checks = 0, fails = 0, ready_mode = 2, last_at = 0;
  bit m_txd = 0, m_rxd = 0, m_test = 0, pend_txd = 0;
  logic [7:0] got[$];

  always #4 clk = ~clk;

  pkt_mailbox #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_txd) begin m_txd = 1; pend_txd = 0; end
      chk("R7 irq model", {31'd0, irq}, {31'd0, m_txd | m_rxd | m_test});
    end
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = ~tx_ready;
      default: tx_ready = 1'b0;
    endcase
    #1;
    if (tx_valid && tx_ready) begin
      got.push_back(tx_data);
      if (tx_last) begin last_at = got.size(); pend_txd = 1; end
    end
  end

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    if (w == W_ICTL) begin
      if (d[0]) m_txd = 0;
      if (d[1]) m_rxd = 0;
      if (d[31]) m_test = 1;
      else if (d == 0) m_test = 0;
    end
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_word = w;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
    if (w == W_ICTL) m_test = 0;
  endtask

  task automatic rdchk(input logic [3:0] w, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(w, d);
    chk(tag, d, exp);
  endtask

  task automatic rx_byte(input logic [7:0] b, input bit last);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      rx_valid = 1; rx_data = b; rx_last = last;
      #2;
      if (rx_ready) begin
        @(posedge clk); #1;
        done = 1;
      end
    end
    rx_valid = 0; rx_last = 0;
    if (last) m_rxd = 1;
  endtask

  task automatic tx_frame(input int n, input int base, input int mode, input string tag);
    got.delete(); last_at = 0; ready_mode = mode;
    wr(W_TXCNT, n);
    for (int i = 0; i < n; i++) wr(W_TXBUF, 32'hA5A5_A500 | ((base + i) & 255));
    while (got.size() < n) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) chk({tag, " byte"}, {24'd0, got[i]}, (base + i) & 255);
    chk({tag, " last position"}, last_at, n);
    rdchk(W_ICTL, 32'h1, "R7 tx done bit");
    wr(W_ICTL, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R7 reset irq", irq, 0);
    chk("R5 reset tx_valid", tx_valid, 0);
    chk("R8 reset rx_ready", rx_ready, 1);
    rdchk(W_IDLO, 32'h5350494D, "R1 id low");
    rdchk(W_IDHI, 32'h3054454E, "R1 id high");
    rdchk(W_BUSY, 0, "R2 idle busy");
    rdchk(W_RXCNT, 0, "R3 reset rx count");
    rdchk(W_TXCNT, 0, "R5 reset tx count");
    rdchk(W_ICTL, 0, "R7 reset ictl");
    rdchk(W_INFO, 32'h2, "R10 info");
    rdchk(4'd11, 0, "R10 unmapped");

    // R10: read-only words ignore writes
    wr(W_IDLO, 32'hFFFF_FFFF); wr(W_BUSY, 3); wr(W_RXCNT, 5); wr(W_INFO, 32'h77);
    rdchk(W_IDLO, 32'h5350494D, "R10 id unchanged");
    rdchk(W_BUSY, 0, "R10 busy unchanged");
    rdchk(W_RXCNT, 0, "R10 rx count unchanged");
    rdchk(W_INFO, 32'h2, "R10 info unchanged");

    // R5/R2: stream only after all bytes, ready held low
    got.delete(); last_at = 0; ready_mode = 2;
    wr(W_TXCNT, 5);
    for (int i = 0; i < 4; i++) wr(W_TXBUF, 32'hFFFF_FF00 | (8'h30 + i));
    rdchk(W_TXCNT, 5, "R5 tx length readback");
    chk("R5 no early start", tx_valid, 0);
    wr(W_TXBUF, 32'h1234_5634);
    rdchk(W_TXCNT, 0, "R5 tx count cleared");
    rdchk(W_BUSY, 1, "R2 tx busy");
    chk("R5 stream started", tx_valid, 1);
    wr(W_TXCNT, 9); wr(W_TXBUF, 32'h99);
    rdchk(W_TXCNT, 0, "R5 length write ignored while streaming");
    ready_mode = 0;
    while (got.size() < 5) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) chk("R6 tx byte held-ready", {24'd0, got[i]}, 8'h30 + i);
    chk("R6 last position", last_at, 5);
    rdchk(W_BUSY, 0, "R2 busy after tx");
    rdchk(W_ICTL, 1, "R7 tx done bit");
    wr(W_ICTL, 1);
    rdchk(W_ICTL, 0, "R7 tx done cleared");

    // R11: length clamp, full depth frame with toggling ready
    wr(W_TXCNT, 20);
    rdchk(W_TXCNT, DEPTH, "R11 tx length clamp");
    tx_frame(DEPTH, 8'h60, 1, "R6 depth frame toggling");
    tx_frame(1, 8'hC7, 0, "R6 single byte");

    // R3: receive 4 bytes
    for (int i = 0; i < 4; i++) rx_byte(8'h10 + i, i == 3);
    @(negedge clk); #2;
    chk("R8 ready low after frame", rx_ready, 0);
    rdchk(W_RXCNT, 4, "R3 rx count loaded");
    rdchk(W_ICTL, 2, "R7 rx bit set");
    for (int i = 0; i < 4; i++) begin
      rdchk(W_RXBUF, 8'h10 + i, "R3 rx byte");
      rdchk(W_RXCNT, 3 - i, "R3 rx count falls");
    end
    rdchk(W_RXBUF, 0, "R4 empty read");
    rdchk(W_RXCNT, 0, "R4 no underflow");

    // R8: frame offered while rx bit still set
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'hEE; rx_last = 1;
      #2 chk("R8 blocked while bit set", rx_ready, 0);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
    rdchk(W_RXCNT, 0, "R8 blocked frame not taken");
    wr(W_ICTL, 2);
    @(negedge clk); #2;
    chk("R8 ready after clear", rx_ready, 1);

    // R2: receive busy across a pause
    rx_byte(8'hA1, 0);
    rdchk(W_BUSY, 2, "R2 rx busy");
    rx_byte(8'hA2, 1);
    rdchk(W_BUSY, 0, "R2 rx busy drops");
    rdchk(W_RXCNT, 2, "R3 two-byte count");
    rdchk(W_RXBUF, 8'hA1, "R3 first");
    rdchk(W_RXBUF, 8'hA2, "R3 second");
    wr(W_ICTL, 2);

    // R11: oversize receive frame
    for (int i = 0; i < 20; i++) rx_byte(8'h40 + i, i == 19);
    rdchk(W_RXCNT, DEPTH, "R11 rx count saturates");
    for (int i = 0; i < DEPTH; i++) rdchk(W_RXBUF, 8'h40 + i, "R11 rx kept byte");
    rdchk(W_RXBUF, 0, "R11 excess dropped");
    wr(W_ICTL, 2);

    // R9: test interrupt
    wr(W_ICTL, 32'h8000_0000);
    @(negedge clk); #2 chk("R9 irq from test", irq, 1);
    wr(W_ICTL, 32'h1);
    @(negedge clk); #2 chk("R9 w1 to bit0 keeps test", irq, 1);
    rdchk(W_ICTL, 32'h8000_0000, "R9 test readback");
    rdchk(W_ICTL, 0, "R9 clears after read");
    wr(W_ICTL, 32'h8000_0000);
    wr(W_ICTL, 0);
    rdchk(W_ICTL, 0, "R9 write zero clears");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule